// File: doc/BRIEF.md
# Capture/Compare Channel With Preload

This block is one channel of a general-purpose timer. It does not own a counter. It watches a count value supplied from outside and works in one of two exclusive personalities. In capture mode it picks one of eight source lines, cleans the selected line with a programmable stability filter, detects the chosen edge and stores the current count in its capture/compare register. In compare mode the same register holds a compare value, and the channel drives a waveform from that value and the count.

A compare value may be written straight into the active register. When preload is on, it is written into a shadow and moved across later, on the first of three events: a timer update, a match against the value still in use, or a software generate command. Three sticky flags report capture, over-capture and compare match. Each flag has its own interrupt enable. A one-cycle trigger pulse marks every capture or match event for neighbouring logic.

Top module: `ccchan_top`

## Requirements
- R1: Only the source line picked by `cfg_src_sel` (index 0 to 7) can cause a capture. Activity on the other seven lines has no effect.
- R2: The edge select `cfg_edge` works as follows: 0 captures on rising edges of the filtered line, 1 on falling edges, and 2 or 3 on both edges.
- R3: The source line is first registered. With filter value N, the registered value must differ from the accepted level for N+1 consecutive clocks before the level changes. Shorter pulses are discarded.
- R4: A capture stores the count present at the clock edge after the filtered level changes, or the count at the edge where `sw_ccg` is high. A capture happens only when `cfg_en` and `cfg_cap_mode` are both 1.
- R5: Every capture sets `flag_cap`. A capture that happens while `flag_cap` is already set also sets `flag_ovc`. The bits of `clr_flags` clear flags as follows: bit0 clears capture, bit1 clears over-capture, bit2 clears match. A flag set in the same cycle as its clear stays set.
- R6: In compare mode with preload off, a write (`wr_ccr`) reaches `ccr_val` at the next clock edge.
- R7: With preload on, a write goes to a shadow register. The shadow moves into `ccr_val` only on `upd_pulse`, on a match of the count with the old value, or on `sw_ccg`, and only in compare mode.
- R8: A match means the channel is enabled, in compare mode, and `count == ccr_val`. On a match, `cfg_mode` acts as follows: 0 holds the output, 1 drives it active, 2 drives it inactive, 3 toggles it. Mode 4 forces it inactive and mode 5 forces it active.
- R9: In mode 6 the output is active at the edge after a count below `ccr_val`. In mode 7 it is active at the edge after a count at or above `ccr_val`. `cfg_pol` = 1 inverts the output after the mode logic.
- R10: `irq` is high while any flag is set whose enable bit in `cfg_irq_en` is set; the bit order is the same as `clr_flags`. `trig_pulse` is high for one cycle, one clock after each capture or match event.
- R11: In capture mode, or when the channel is disabled, no match occurs and `wave_out` rests at its inactive level (equal to `cfg_pol`). In compare mode, source edges cause no capture.
- R12: After reset, `ccr_val`, all flags, `trig_pulse` and `irq` are 0, and `wave_out` equals `cfg_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count | input | CNT_W | Timer count value |
| upd_pulse | input | 1 | Update event from the timer (already qualified by its update enable) |
| src_in | input | 8 | Capture source lines |
| cfg_en | input | 1 | Channel enable |
| cfg_cap_mode | input | 1 | 1 = capture, 0 = compare |
| cfg_src_sel | input | 3 | Capture source index |
| cfg_edge | input | 2 | Capture edge select |
| cfg_filt | input | 8 | Filter length N |
| cfg_mode | input | 3 | Output mode |
| cfg_pol | input | 1 | 1 = active-low output |
| cfg_preload | input | 1 | Compare preload enable |
| cfg_irq_en | input | 3 | Interrupt enables {match, over-capture, capture} |
| wr_ccr | input | 1 | Write strobe for the capture/compare value |
| wr_data | input | CNT_W | Write data |
| sw_ccg | input | 1 | Software capture/compare generate pulse |
| clr_flags | input | 3 | Flag clear strobes {match, over-capture, capture} |
| ccr_val | output | CNT_W | Active capture/compare value |
| wave_out | output | 1 | Compare waveform |
| trig_pulse | output | 1 | One-cycle event trigger |
| flag_cap | output | 1 | Capture flag |
| flag_ovc | output | 1 | Over-capture flag |
| flag_match | output | 1 | Compare match flag |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume three things about the inputs: `count` stays within `CNT_W` bits, the configuration changes only between clock edges, and `sw_ccg`, `upd_pulse` and `wr_ccr` are single-cycle strobes. The preload check also assumes that no capture lands while the channel is in compare mode. The stimulus changes every input on the falling clock edge only. It switches personality only while the channel sits idle. It keeps the count either frozen or stepping through a small wrapping range, so that every match instant can be predicted.

// File: rtl/ccchan_pkg.sv
package ccchan_pkg;

    localparam int NUM_SRC = 8;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int FLT_W   = 8;
    localparam int NUM_FLG = 3;

    typedef enum logic [2:0] {
        OCM_HOLD     = 3'd0,
        OCM_SET_HI   = 3'd1,
        OCM_SET_LO   = 3'd2,
        OCM_FLIP     = 3'd3,
        OCM_FORCE_LO = 3'd4,
        OCM_FORCE_HI = 3'd5,
        OCM_PWM_LT   = 3'd6,
        OCM_PWM_GE   = 3'd7
    } ocm_e;

    typedef enum logic [1:0] {
        EDG_RISE = 2'd0,
        EDG_FALL = 2'd1,
        EDG_ANY  = 2'd2,
        EDG_ANY2 = 2'd3
    } edg_e;

    // flag vector order: bit0 capture, bit1 over-capture, bit2 match
    typedef struct packed {
        logic match;
        logic ovc;
        logic cap;
    } flags_t;

    function automatic logic edge_ok(edg_e sel, logic new_lvl);
        case (sel)
            EDG_RISE: return new_lvl;
            EDG_FALL: return !new_lvl;
            default:  return 1'b1;
        endcase
    endfunction

    function automatic logic next_ref(ocm_e m, logic cur, logic hit, logic below);
        case (m)
            OCM_HOLD:     return cur;
            OCM_SET_HI:   return hit ? 1'b1 : cur;
            OCM_SET_LO:   return hit ? 1'b0 : cur;
            OCM_FLIP:     return hit ? !cur : cur;
            OCM_FORCE_LO: return 1'b0;
            OCM_FORCE_HI: return 1'b1;
            OCM_PWM_LT:   return below;
            default:      return !below;
        endcase
    endfunction

endpackage

// File: rtl/ccchan_infilt.sv
module ccchan_infilt
    import ccchan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [SEL_W-1:0]   sel,
    input  edg_e               edg,
    input  logic [FLT_W-1:0]   filt,
    output logic               edge_q
);
    logic             samp_q;
    logic             lvl_q;
    logic [FLT_W-1:0] run_q;
    logic             picked;

    assign picked = src_in[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
            lvl_q  <= 1'b0;
            run_q  <= '0;
            edge_q <= 1'b0;
        end else begin
            samp_q <= picked;
            edge_q <= 1'b0;
            if (samp_q != lvl_q) begin
                if (run_q == filt) begin
                    lvl_q  <= samp_q;
                    run_q  <= '0;
                    edge_q <= edge_ok(edg, samp_q);
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/ccchan_ccreg.sv
module ccchan_ccreg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic             cap_ev,
    input  logic             cmp_side,
    input  logic             commit_req,
    input  logic             preload,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] ccr
);
    logic [CNT_W-1:0] shadow_q;
    logic             pend_q;
    logic             commit;

    assign commit = cmp_side && pend_q && commit_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr      <= '0;
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (cap_ev)
                ccr <= count;
            else if (commit)
                ccr <= shadow_q;
            else if (wr && !preload)
                ccr <= wr_data;

            if (wr && preload) begin
                shadow_q <= wr_data;
                pend_q   <= 1'b1;
            end else if (commit) begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ccchan_wavegen.sv
module ccchan_wavegen
    import ccchan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  ocm_e             mode,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] ccr,
    input  logic             hit,
    output logic             ref_q
);
    logic below;

    assign below = (count < ccr);

    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= 1'b0;
        else if (!active)
            ref_q <= 1'b0;
        else
            ref_q <= next_ref(mode, ref_q, hit, below);
    end
endmodule

// File: rtl/ccchan_top.sv
module ccchan_top
    import ccchan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   count,
    input  logic               upd_pulse,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               cfg_en,
    input  logic               cfg_cap_mode,
    input  logic [SEL_W-1:0]   cfg_src_sel,
    input  logic [1:0]         cfg_edge,
    input  logic [FLT_W-1:0]   cfg_filt,
    input  logic [2:0]         cfg_mode,
    input  logic               cfg_pol,
    input  logic               cfg_preload,
    input  logic [2:0]         cfg_irq_en,
    input  logic               wr_ccr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic               sw_ccg,
    input  logic [2:0]         clr_flags,
    output logic [CNT_W-1:0]   ccr_val,
    output logic               wave_out,
    output logic               trig_pulse,
    output logic               flag_cap,
    output logic               flag_ovc,
    output logic               flag_match,
    output logic               irq
);
    logic   edge_q;
    logic   cap_ev;
    logic   match_ev;
    logic   ref_q;
    flags_t flg_q;
    flags_t flg_set;
    flags_t flg_clr;

    ccchan_infilt u_filt (
        .clk    (clk),
        .rst    (rst),
        .src_in (src_in),
        .sel    (cfg_src_sel),
        .edg    (edg_e'(cfg_edge)),
        .filt   (cfg_filt),
        .edge_q (edge_q)
    );

    assign cap_ev   = cfg_en && cfg_cap_mode && (edge_q || sw_ccg);
    assign match_ev = cfg_en && !cfg_cap_mode && (count == ccr_val);

    ccchan_ccreg #(.CNT_W(CNT_W)) u_ccr (
        .clk        (clk),
        .rst        (rst),
        .count      (count),
        .cap_ev     (cap_ev),
        .cmp_side   (!cfg_cap_mode),
        .commit_req (upd_pulse || match_ev || sw_ccg),
        .preload    (cfg_preload),
        .wr         (wr_ccr),
        .wr_data    (wr_data),
        .ccr        (ccr_val)
    );

    ccchan_wavegen #(.CNT_W(CNT_W)) u_wave (
        .clk    (clk),
        .rst    (rst),
        .active (cfg_en && !cfg_cap_mode),
        .mode   (ocm_e'(cfg_mode)),
        .count  (count),
        .ccr    (ccr_val),
        .hit    (match_ev),
        .ref_q  (ref_q)
    );

    assign flg_set.cap   = cap_ev;
    assign flg_set.ovc   = cap_ev && flg_q.cap;
    assign flg_set.match = match_ev;
    assign flg_clr       = flags_t'(clr_flags);

    // sticky flags, set wins over clear
    for (genvar i = 0; i < NUM_FLG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flg_q[i] <= 1'b0;
            else if (flg_set[i])
                flg_q[i] <= 1'b1;
            else if (flg_clr[i])
                flg_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            trig_pulse <= 1'b0;
        else
            trig_pulse <= cap_ev || match_ev;
    end

    assign wave_out   = ref_q ^ cfg_pol;
    assign flag_cap   = flg_q.cap;
    assign flag_ovc   = flg_q.ovc;
    assign flag_match = flg_q.match;
    assign irq        = |(flg_q & flags_t'(cfg_irq_en));

endmodule

// File: rtl/ccchan_chk.sv
module ccchan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic             upd_pulse,
    input logic             cfg_en,
    input logic             cfg_cap_mode,
    input logic [2:0]       cfg_mode,
    input logic             cfg_pol,
    input logic             cfg_preload,
    input logic             sw_ccg,
    input logic [CNT_W-1:0] ccr_val,
    input logic             wave_out,
    input logic             trig_pulse,
    input logic             flag_cap,
    input logic             flag_ovc,
    input logic             flag_match
);
    // R5
    ovc_needs_cap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_ovc) |-> $past(flag_cap));

    // R10
    trig_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> (flag_cap || flag_match));

    // R11
    cap_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_cap_mode && $past(cfg_cap_mode)) |-> (wave_out == cfg_pol && !$rose(flag_match)));

    // R8
    force_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !cfg_cap_mode && $past(cfg_en) && !$past(cfg_cap_mode)
         && cfg_mode == 3'd5 && $past(cfg_mode) == 3'd5) |-> (wave_out == !cfg_pol));

    // R7
    preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_preload) && !$past(cfg_cap_mode) && !$past(upd_pulse) && !$past(sw_ccg)
         && !($past(cfg_en) && $past(count) == $past(ccr_val))) |-> $stable(ccr_val));

endmodule

bind ccchan_top ccchan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .count        (count),
    .upd_pulse    (upd_pulse),
    .cfg_en       (cfg_en),
    .cfg_cap_mode (cfg_cap_mode),
    .cfg_mode     (cfg_mode),
    .cfg_pol      (cfg_pol),
    .cfg_preload  (cfg_preload),
    .sw_ccg       (sw_ccg),
    .ccr_val      (ccr_val),
    .wave_out     (wave_out),
    .trig_pulse   (trig_pulse),
    .flag_cap     (flag_cap),
    .flag_ovc     (flag_ovc),
    .flag_match   (flag_match)
);

// File: tb/sim_ccchan_top.sv
`timescale 1ns/1ps
module sim_ccchan_top;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CW-1:0] count = '0;
    logic upd_pulse = 1'b0;
    logic [7:0] src_in = '0;
    logic cfg_en = 1'b0, cfg_cap_mode = 1'b0;
    logic [2:0] cfg_src_sel = '0;
    logic [1:0] cfg_edge = '0;
    logic [7:0] cfg_filt = '0;
    logic [2:0] cfg_mode = '0;
    logic cfg_pol = 1'b0, cfg_preload = 1'b0;
    logic [2:0] cfg_irq_en = '0;
    logic wr_ccr = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic sw_ccg = 1'b0;
    logic [2:0] clr_flags = '0;

    logic [CW-1:0] ccr_val;
    logic wave_out, trig_pulse, flag_cap, flag_ovc, flag_match, irq;

    int checks = 0;
    int failures = 0;
    string cur_req = "R12";
    bit cnt_run = 1'b0;
    int cnt_top = 9;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ccchan_top #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .count(count), .upd_pulse(upd_pulse), .src_in(src_in),
        .cfg_en(cfg_en), .cfg_cap_mode(cfg_cap_mode), .cfg_src_sel(cfg_src_sel),
        .cfg_edge(cfg_edge), .cfg_filt(cfg_filt), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
        .cfg_preload(cfg_preload), .cfg_irq_en(cfg_irq_en), .wr_ccr(wr_ccr),
        .wr_data(wr_data), .sw_ccg(sw_ccg), .clr_flags(clr_flags), .ccr_val(ccr_val),
        .wave_out(wave_out), .trig_pulse(trig_pulse), .flag_cap(flag_cap),
        .flag_ovc(flag_ovc), .flag_match(flag_match), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    int m_samp, m_lvl, m_run, m_edge, m_ccr, m_shd, m_pend;
    int m_fc, m_fo, m_fm, m_ref, m_trig;

    always @(posedge clk) begin
        int capx, hit, cmt, below, nl;
        if (rst) begin
            m_samp = 0; m_lvl = 0; m_run = 0; m_edge = 0; m_ccr = 0; m_shd = 0;
            m_pend = 0; m_fc = 0; m_fo = 0; m_fm = 0; m_ref = 0; m_trig = 0;
        end else begin
            capx  = (cfg_en && cfg_cap_mode && (m_edge != 0 || sw_ccg)) ? 1 : 0;
            hit   = (cfg_en && !cfg_cap_mode && int'(count) == m_ccr) ? 1 : 0;
            cmt   = (!cfg_cap_mode && m_pend != 0 && (upd_pulse || hit != 0 || sw_ccg)) ? 1 : 0;
            below = (int'(count) < m_ccr) ? 1 : 0;
            // output reference level
            if (!cfg_en || cfg_cap_mode) m_ref = 0;
            else case (cfg_mode)
                3'd1: if (hit != 0) m_ref = 1;
                3'd2: if (hit != 0) m_ref = 0;
                3'd3: if (hit != 0) m_ref = 1 - m_ref;
                3'd4: m_ref = 0;
                3'd5: m_ref = 1;
                3'd6: m_ref = below;
                3'd7: m_ref = 1 - below;
                default: ;
            endcase
            // flags
            m_fo = (capx != 0 && m_fc != 0) ? 1 : (clr_flags[1] ? 0 : m_fo);
            m_fc = (capx != 0) ? 1 : (clr_flags[0] ? 0 : m_fc);
            m_fm = (hit != 0) ? 1 : (clr_flags[2] ? 0 : m_fm);
            m_trig = (capx != 0 || hit != 0) ? 1 : 0;
            // value register
            if (capx != 0) m_ccr = int'(count);
            else if (cmt != 0) m_ccr = m_shd;
            else if (wr_ccr && !cfg_preload) m_ccr = int'(wr_data);
            if (wr_ccr && cfg_preload) begin m_shd = int'(wr_data); m_pend = 1; end
            else if (cmt != 0) m_pend = 0;
            // filter
            m_edge = 0;
            if (m_samp != m_lvl) begin
                if (m_run == int'(cfg_filt)) begin
                    nl = m_samp; m_lvl = nl; m_run = 0;
                    m_edge = (cfg_edge == 2'd0) ? nl : (cfg_edge == 2'd1) ? 1 - nl : 1;
                end else m_run = m_run + 1;
            end else m_run = 0;
            m_samp = src_in[cfg_src_sel] ? 1 : 0;
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    // compare every clock, 2 ns after the rising edge
    always @(posedge clk) begin
        #2;
        if (!done) begin
            chk("ccr_val", int'(ccr_val), m_ccr);
            chk("wave_out", int'(wave_out), m_ref ^ int'(cfg_pol));
            chk("trig_pulse", int'(trig_pulse), m_trig);
            chk("flag_cap", int'(flag_cap), m_fc);
            chk("flag_ovc", int'(flag_ovc), m_fo);
            chk("flag_match", int'(flag_match), m_fm);
            chk("irq", int'(irq), ((m_fc & int'(cfg_irq_en[0])) | (m_fo & int'(cfg_irq_en[1]))
                                   | (m_fm & int'(cfg_irq_en[2]))));
        end
    end

    always @(negedge clk)
        if (cnt_run) count = (int'(count) >= cnt_top) ? '0 : count + 1'b1;

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr_flags = 3'b111; step(1); clr_flags = 3'b000;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        step(3);
        // R12: reset state
        chk("reset ccr", int'(ccr_val), 0);
        chk("reset flags", int'({flag_cap, flag_ovc, flag_match, trig_pulse, irq}), 0);
        chk("reset wave", int'(wave_out), 0);
        rst = 1'b0;
        step(2);

        // R1: capture mode, source 2 selected, rising edge, no filter
        cur_req = "R1";
        cfg_en = 1; cfg_cap_mode = 1; cfg_src_sel = 3'd2; cfg_edge = 2'd0; cfg_filt = 0;
        count = 16'd100;
        src_in[5] = 1; step(4); src_in[5] = 0; step(4);
        chk("unselected source ignored", int'(flag_cap), 0);
        src_in[2] = 1; step(4);
        chk("selected source captured", int'(flag_cap), 1);
        chk("captured count", int'(ccr_val), 100);
        pulse_clear();

        // R2: falling edge and both edges
        cur_req = "R2";
        cfg_edge = 2'd0; count = 16'd200; src_in[2] = 0; step(4);
        chk("rise mode ignores fall", int'(flag_cap), 0);
        cfg_edge = 2'd1; src_in[2] = 1; step(4);
        chk("fall mode ignores rise", int'(flag_cap), 0);
        src_in[2] = 0; step(4);
        chk("fall mode captures", int'(flag_cap), 1);
        pulse_clear();
        cfg_edge = 2'd2; cnt_run = 1; cnt_top = 50;
        for (int k = 0; k < 4; k++) begin src_in[2] = ~src_in[2]; step(5); end
        cnt_run = 0;
        pulse_clear();

        // R3: filter of 3 rejects a 3-cycle pulse, accepts a long one
        cur_req = "R3";
        cfg_filt = 8'd3; cfg_edge = 2'd0; src_in[2] = 0; step(8); pulse_clear();
        src_in[2] = 1; step(3); src_in[2] = 0; step(8);
        chk("short pulse rejected", int'(flag_cap), 0);
        src_in[2] = 1; step(8);
        chk("long pulse accepted", int'(flag_cap), 1);
        src_in[2] = 0; step(8); cfg_filt = 0; pulse_clear();

        // R4: software capture stores the count at that edge
        cur_req = "R4";
        count = 16'd77; sw_ccg = 1; step(1); sw_ccg = 0;
        chk("sw capture value", int'(ccr_val), 77);

        // R5: over-capture and clearing
        cur_req = "R5";
        count = 16'd88; sw_ccg = 1; step(1); sw_ccg = 0; step(1);
        chk("over-capture set", int'(flag_ovc), 1);
        clr_flags = 3'b011; step(1); clr_flags = 0;
        chk("flags cleared", int'({flag_cap, flag_ovc}), 0);

        // R10: interrupt enables and trigger pulse
        cur_req = "R10";
        cfg_irq_en = 3'b001; sw_ccg = 1; step(1); sw_ccg = 0;
        chk("irq from capture", int'(irq), 1);
        cfg_irq_en = 3'b100; step(1);
        chk("irq masked", int'(irq), 0);
        pulse_clear(); cfg_irq_en = 3'b111;

        // R11: compare mode ignores source edges
        cur_req = "R11";
        cfg_cap_mode = 0; cfg_mode = 3'd0; count = 16'd999;
        src_in[2] = 1; step(4); src_in[2] = 0; step(4);
        chk("no capture in compare mode", int'(flag_cap), 0);

        // R6: direct write
        cur_req = "R6";
        cfg_preload = 0; count = 16'd500; wr_ccr = 1; wr_data = 16'd10; step(1); wr_ccr = 0;
        chk("direct write", int'(ccr_val), 10);

        // R7: preload with three commit events
        cur_req = "R7";
        cfg_preload = 1; wr_ccr = 1; wr_data = 16'd20; step(1); wr_ccr = 0; step(2);
        chk("held in shadow", int'(ccr_val), 10);
        upd_pulse = 1; step(1); upd_pulse = 0;
        chk("commit on update", int'(ccr_val), 20);
        wr_ccr = 1; wr_data = 16'd30; step(1); wr_ccr = 0;
        count = 16'd20; step(1); count = 16'd500;
        chk("commit on old match", int'(ccr_val), 30);
        wr_ccr = 1; wr_data = 16'd40; step(1); wr_ccr = 0;
        sw_ccg = 1; step(1); sw_ccg = 0;
        chk("commit on sw generate", int'(ccr_val), 40);
        cfg_preload = 0; pulse_clear();

        // R8: match-driven modes
        cur_req = "R8";
        cfg_mode = 3'd1; count = 16'd40; step(1); count = 16'd500; step(1);
        chk("set active on match", int'(wave_out), 1);
        cfg_mode = 3'd2; count = 16'd40; step(1); count = 16'd500; step(1);
        chk("set inactive on match", int'(wave_out), 0);
        cfg_mode = 3'd3; cnt_run = 1; cnt_top = 45; count = 16'd35; step(30); cnt_run = 0;
        cfg_mode = 3'd5; step(2);
        chk("forced active", int'(wave_out), 1);
        cfg_mode = 3'd4; step(2);
        chk("forced inactive", int'(wave_out), 0);

        // R9: PWM modes and polarity
        cur_req = "R9";
        wr_ccr = 1; wr_data = 16'd4; step(1); wr_ccr = 0;
        cfg_mode = 3'd6; count = 16'd2; step(1);
        chk("pwm1 below", int'(wave_out), 1);
        count = 16'd6; step(1);
        chk("pwm1 above", int'(wave_out), 0);
        cfg_pol = 1; step(1);
        chk("pwm1 inverted", int'(wave_out), 1);
        cfg_mode = 3'd7; cnt_run = 1; cnt_top = 9; step(25);
        cfg_pol = 0; cfg_mode = 3'd6; step(25); cnt_run = 0;

        // R11: capture mode keeps the output inactive
        cur_req = "R11";
        cfg_mode = 3'd5; cfg_cap_mode = 1; step(2);
        chk("capture mode output idle", int'(wave_out), 0);
        cfg_en = 0; cfg_cap_mode = 0; step(2);
        chk("disabled output idle", int'(wave_out), 0);
        step(2);
        summary();
    end
endmodule